// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a synthesizable model of a single-port synchronous SRAM. It is built so that reads and writes can follow each other on every clock with no idle cycles. All inputs are sampled on the rising clock edge, and an active-low clock enable gates each edge. When that enable is high, the whole block freezes: the address sequencer, the access type and any write not yet committed all keep their values.

An access starts when three conditions hold at an edge: the clock enable is low, load/advance is low and all three chip selects are active. A read puts the array word on the output bus during the cycle right after that edge, and the word is driven only while the asynchronous output enable is low. A write takes its data one enabled edge after the command. The model first holds that data in a pending register, then commits it to the array on the following enabled edge. A read of a pending word is served from the pending register, merged with its lane mask.

With load/advance high, a 2-bit burst counter steps the low address bits, in linear or interleaved order. The access type latched when the burst was loaded stays in force for the whole burst. The data word is four 9-bit lanes. The shared data bus is presented as separate in, out and drive-enable signals, so that the pad can be placed outside the block.

Top module: `zbt_sram`

## Requirements
- R1: While `cen_n` is 1, a clock edge changes nothing. A read in progress keeps driving the same word. A write whose data is due is not captured until the next edge with `cen_n` 0, and the value on `dq_in` at that later edge is the one stored. A burst does not advance.
- R2: An edge with `cen_n`=0 and `adv_ld_n`=0 starts an access only if `sel0_n`=0, `sel1`=1 and `sel2_n`=0. `we_n`=0 selects a write and `we_n`=1 selects a read. A command given with any select inactive neither writes nor drives the bus.
- R3: For a write command on edge N, `dq_drive` is 0 during the following cycle, whatever `oe_n` is. The word on `dq_in` at the next enabled edge N+1 is stored. Edge N+1 may carry a new command, so back-to-back writes and read/write alternation need no idle cycles.
- R4: A write updates lane i, bits [9i+8:9i], only when `bw_n[i]` is 0 at the edge where the command or advance for that beat is given. Every other lane keeps its old contents.
- R5: For a read command or read beat on edge N, `dq_out` shows the stored word during the cycle after N. `dq_drive` equals the inverse of `oe_n` in that cycle.
- R6: A command edge with a chip select inactive sets `dq_drive` to 0 in the next cycle. Advance edges that follow a deselect do nothing until a new address is loaded.
- R7: With `adv_ld_n`=1 and `cen_n`=0, the burst counter k steps by one, modulo 4, whatever the selects and `we_n` are. The access type of the burst is kept. Address bits [1:0] of beat k are the loaded bits plus k, modulo 4, when `burst_order`=0, and the loaded bits XOR k when `burst_order`=1. The upper address bits do not change.
- R8: A read of a word whose write data has been captured but not yet committed returns the new data in the selected lanes and the old data in the other lanes.
- R9: While `rst_n` is 0 and after its release, the block is idle and `dq_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset of the control state |
| cen_n | input | 1 | Active-low clock enable |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| adv_ld_n | input | 1 | 0 loads a new address and access type, 1 advances the burst |
| we_n | input | 1 | 0 write, 1 read, sampled on load |
| bw_n | input | LANES | Active-low per-lane write selects |
| burst_order | input | 1 | 0 linear, 1 interleaved burst order |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_in | input | LANES*LANE_W | Write data from the bus |
| dq_out | output | LANES*LANE_W | Read data to the bus |
| dq_drive | output | 1 | 1 when the block drives the bus |

## Verification
A read given on an edge is checked in the cycle after it, half a clock after the edge and just after `oe_n` is set. The bench checks `dq_drive` there and compares `dq_out` with a reference array. A write's data is presented through the whole cycle after its command edge. The reference array is updated only at the next enabled edge, which also carries the following command, so a read directly after a write tests forwarding. Stalled edges leave the reference model unchanged and put inverted data on `dq_in`. Any capture during a stall then appears in a later read-back.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    localparam int BURST_W = 2;
endpackage

// File: rtl/zbt_seq_addr.sv
module zbt_seq_addr #(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0]            base,
    input  logic [zbt_pkg::BURST_W-1:0]  beat,
    input  logic                         order,
    output logic [ADDR_W-1:0]            eff
);
    localparam int BW = zbt_pkg::BURST_W;

    logic [BW-1:0] low;

    generate
        if (ADDR_W > BW) begin : g_wide
            assign eff = {base[ADDR_W-1:BW], low};
        end else begin : g_narrow
            assign eff = low[ADDR_W-1:0];
        end
    endgenerate

    // interleaved: XOR of the beat index; linear: modular add
    always_comb begin
        if (order) low = base[BW-1:0] ^ beat;
        else       low = base[BW-1:0] + beat;
    end
endmodule

// File: rtl/zbt_core.sv
module zbt_core #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int WORD_W = LANES * LANE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              commit,
    input  logic              pend_vld,
    input  logic [ADDR_W-1:0] pend_addr,
    input  logic [LANES-1:0]  pend_bw_n,
    input  logic [WORD_W-1:0] pend_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] raw;
    logic              hit;

    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < LANES; i++) begin
                if (!pend_bw_n[i])
                    mem[pend_addr][i*LANE_W +: LANE_W] <= pend_data[i*LANE_W +: LANE_W];
            end
        end
    end

    assign raw = mem[rd_addr];
    assign hit = pend_vld && (pend_addr == rd_addr);

    // forward the pending word lane by lane
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign rd_data[g*LANE_W +: LANE_W] = (hit && !pend_bw_n[g])
                ? pend_data[g*LANE_W +: LANE_W]
                : raw[g*LANE_W +: LANE_W];
        end
    endgenerate
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cen_n,
    input  logic              sel0_n,
    input  logic              sel1,
    input  logic              sel2_n,
    input  logic              adv_ld_n,
    input  logic              we_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic              burst_order,
    input  logic [ADDR_W-1:0] addr,
    input  logic              oe_n,
    input  logic [WORD_W-1:0] dq_in,
    output logic [WORD_W-1:0] dq_out,
    output logic              dq_drive
);
    import zbt_pkg::*;

    typedef struct packed {
        op_e                op;
        logic [ADDR_W-1:0]  base;
        logic [BURST_W-1:0] beat;
        logic [LANES-1:0]   bw_n;
        logic               pv;
        logic [ADDR_W-1:0]  pa;
        logic [LANES-1:0]   pbw_n;
        logic [WORD_W-1:0]  pd;
    } state_t;

    state_t            st_d, st_q;
    logic              sel_all;
    logic [ADDR_W-1:0] eff_addr;
    logic [WORD_W-1:0] rd_word;

    assign sel_all = !sel0_n && sel1 && !sel2_n;

    zbt_seq_addr #(.ADDR_W(ADDR_W)) i_seq (
        .base  (st_q.base),
        .beat  (st_q.beat),
        .order (burst_order),
        .eff   (eff_addr)
    );

    zbt_core #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_core (
        .clk       (clk),
        .commit    (!cen_n && st_q.pv),
        .pend_vld  (st_q.pv),
        .pend_addr (st_q.pa),
        .pend_bw_n (st_q.pbw_n),
        .pend_data (st_q.pd),
        .rd_addr   (eff_addr),
        .rd_data   (rd_word)
    );

    always_comb begin
        st_d = st_q;
        if (!cen_n) begin
            // data phase of the beat registered on the previous edge
            if (st_q.op == OP_WRITE) begin
                st_d.pv    = 1'b1;
                st_d.pa    = eff_addr;
                st_d.pbw_n = st_q.bw_n;
                st_d.pd    = dq_in;
            end else begin
                st_d.pv = 1'b0;
            end
            // command phase
            if (!adv_ld_n) begin
                if (sel_all) begin
                    st_d.op   = we_n ? OP_READ : OP_WRITE;
                    st_d.base = addr;
                    st_d.beat = '0;
                    st_d.bw_n = bw_n;
                end else begin
                    st_d.op = OP_IDLE;
                end
            end else if (st_q.op != OP_IDLE) begin
                st_d.beat = st_q.beat + 1'b1;
                st_d.bw_n = bw_n;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{op: OP_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign dq_out   = rd_word;
    assign dq_drive = (st_q.op == OP_READ) && !oe_n;

    p_stall_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n |=> $stable(st_q));

    p_write_float_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !adv_ld_n && sel_all && !we_n) |=> !dq_drive);

    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && st_q.op == OP_WRITE) |=> st_q.pv);

    p_deselect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !adv_ld_n && !sel_all) |=> !dq_drive);

    p_burst_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && adv_ld_n && st_q.op != OP_IDLE) |=> st_q.beat == $past(st_q.beat) + 2'd1);

    p_reset_idle_r9: assert property (@(posedge clk)
        !rst_n |-> !dq_drive);
endmodule

// File: tb/test_zbt_sram.sv
`timescale 1ns/1ps
module test_zbt_sram;
    localparam int AW = 6;
    localparam int WW = 36;
    localparam int DEPTH = 1 << AW;

    typedef enum int {M_IDLE, M_READ, M_WRITE} mop_e;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cen_n = 1'b0;
    logic          sel0_n = 1'b1, sel1 = 1'b1, sel2_n = 1'b0;
    logic          adv_ld_n = 1'b0, we_n = 1'b1;
    logic [3:0]    bw_n = 4'hF;
    logic          burst_order = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          oe_n = 1'b1;
    logic [WW-1:0] dq_in = '0;
    logic [WW-1:0] dq_out;
    logic          dq_drive;

    int checks = 0;
    int failures = 0;

    logic [WW-1:0] ref_mem [DEPTH];
    mop_e          m_op = M_IDLE;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_beat = '0;
    logic [3:0]    m_bw = 4'hF;
    logic [WW-1:0] pend_wd = '0;

    zbt_sram #(.ADDR_W(AW), .LANES(4), .LANE_W(9)) i_zbt_sram (
        .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .sel0_n(sel0_n), .sel1(sel1),
        .sel2_n(sel2_n), .adv_ld_n(adv_ld_n), .we_n(we_n), .bw_n(bw_n),
        .burst_order(burst_order), .addr(addr), .oe_n(oe_n), .dq_in(dq_in),
        .dq_out(dq_out), .dq_drive(dq_drive)
    );

    always #2 clk = ~clk;

    function automatic logic [WW-1:0] pat(input int a, input int k);
        logic [WW-1:0] v;
        v = WW'(64'h5A5A5A5A5 * (a + 1)) ^ WW'(k * 64'h1F3);
        return v;
    endfunction

    function automatic logic [AW-1:0] eff_of(input logic [AW-1:0] b, input logic [1:0] k);
        logic [1:0] lo;
        lo = burst_order ? (b[1:0] ^ k) : (b[1:0] + k);
        return {b[AW-1:2], lo};
    endfunction

    task automatic chk(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: check outputs of current cycle, drive the next edge, update the model
    task automatic step(input string tag, input bit c_n, input int desel, input bit adv,
                        input bit w_n, input logic [3:0] bw, input int a,
                        input logic [WW-1:0] nd, input bit oe);
        logic [AW-1:0] ea;
        oe_n = oe;
        #0.5;
        ea = eff_of(m_base, m_beat);
        if (m_op == M_READ) begin
            chk(tag, WW'(dq_drive), WW'(!oe));
            if (!oe) chk(tag, dq_out, ref_mem[ea]);
        end else begin
            chk(tag, WW'(dq_drive), '0);
        end
        cen_n    = c_n;
        sel0_n   = (desel == 1);
        sel1     = (desel != 2);
        sel2_n   = (desel == 3);
        adv_ld_n = adv;
        we_n     = w_n;
        bw_n     = bw;
        addr     = AW'(a);
        dq_in    = c_n ? ~pend_wd : pend_wd;
        @(posedge clk);
        if (!c_n) begin
            if (m_op == M_WRITE) begin
                for (int i = 0; i < 4; i++)
                    if (!m_bw[i]) ref_mem[ea][i*9 +: 9] = pend_wd[i*9 +: 9];
            end
            if (!adv) begin
                if (desel == 0) begin
                    m_op   = w_n ? M_READ : M_WRITE;
                    m_base = AW'(a);
                    m_beat = 2'd0;
                    m_bw   = bw;
                end else begin
                    m_op = M_IDLE;
                end
            end else if (m_op != M_IDLE) begin
                m_beat = m_beat + 2'd1;
                m_bw   = bw;
            end
            if (m_op == M_WRITE) pend_wd = nd;
        end
        @(negedge clk);
    endtask

    task automatic nop(input string tag);
        step(tag, 1'b0, 1, 1'b0, 1'b1, 4'hF, 0, '0, 1'b0);
    endtask

    task automatic wr(input string tag, input int a, input logic [3:0] bw, input logic [WW-1:0] d);
        step(tag, 1'b0, 0, 1'b0, 1'b0, bw, a, d, 1'b0);
    endtask

    task automatic rd(input string tag, input int a);
        step(tag, 1'b0, 0, 1'b0, 1'b1, 4'hF, a, '0, 1'b0);
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        chk("R9 drive in reset", WW'(dq_drive), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 drive after reset", WW'(dq_drive), '0);

        // R3: back-to-back full writes over every address, oe_n low during data phases
        for (int a = 0; a < DEPTH; a++) wr("R3 write sweep", a, 4'h0, pat(a, 0));
        nop("R3 last data phase");
        // R5: back-to-back reads of every address
        for (int a = 0; a < DEPTH; a++) rd("R5 read sweep", a);
        for (int a = 0; a < 4; a++) step("R5 oe high", 1'b0, 0, 1'b0, 1'b1, 4'hF, a, '0, 1'b1);
        nop("R5 end");

        // R8 / R3: write then read the same word immediately, alternating
        for (int a = 0; a < 16; a++) begin
            wr("R3 alternate write", a, 4'h0, pat(a, 1));
            rd("R8 forward read", a);
            wr("R3 alternate write", a + 16, 4'h0, pat(a + 16, 1));
            rd("R8 forward read", a + 16);
        end
        nop("R8 end");

        // R4: every lane mask, read right after and once committed
        for (int m = 0; m < 16; m++) begin
            wr("R4 masked write", 40, 4'(m), pat(40, m + 2));
            rd("R4 masked forward", 40);
            rd("R4 masked readback", 40);
        end
        nop("R4 end");

        // R2: commands with one select inactive do nothing
        for (int d = 1; d < 4; d++) begin
            step("R2 deselected write", 1'b0, d, 1'b0, 1'b0, 4'h0, 3, pat(3, 9), 1'b0);
            nop("R2 gap");
            step("R2 deselected read", 1'b0, d, 1'b0, 1'b1, 4'hF, 3, '0, 1'b0);
            rd("R2 unchanged", 3);
        end
        nop("R2 end");

        // R1: stall during write data phase, during a read and within a burst
        wr("R1 write cmd", 50, 4'h0, pat(50, 7));
        step("R1 stall data phase", 1'b1, 0, 1'b0, 1'b1, 4'hF, 1, '0, 1'b0);
        step("R1 stall data phase", 1'b1, 0, 1'b0, 1'b0, 4'h0, 2, '0, 1'b1);
        rd("R1 read after stall", 50);
        rd("R1 read", 10);
        step("R1 stall read", 1'b1, 0, 1'b0, 1'b0, 4'h0, 11, '0, 1'b0);
        step("R1 stall read", 1'b1, 2, 1'b1, 1'b0, 4'h0, 12, '0, 1'b0);
        step("R1 burst beat", 1'b0, 0, 1'b1, 1'b1, 4'hF, 0, '0, 1'b0);
        step("R1 stall burst", 1'b1, 0, 1'b1, 1'b1, 4'hF, 0, '0, 1'b0);
        step("R1 burst beat", 1'b0, 0, 1'b1, 1'b1, 4'hF, 0, '0, 1'b0);
        nop("R1 end");
        rd("R1 no stray write", 1);
        rd("R1 no stray write", 2);
        nop("R1 end");

        // R7: bursts in both orders from every start offset, six beats to wrap
        for (int o = 0; o < 2; o++) begin
            burst_order = 1'(o);
            for (int s = 0; s < 4; s++) begin
                wr("R7 burst write load", 20 + s, 4'h0, pat(s, 30 + o));
                for (int k = 1; k < 6; k++)
                    step("R7 burst write beat", 1'b0, o, 1'b1, 1'b1, 4'h0, 0, pat(s * 8 + k, 40 + o), 1'b0);
                rd("R7 burst read load", 20 + s);
                for (int k = 1; k < 6; k++)
                    step("R7 burst read beat", 1'b0, o * 3, 1'b1, 1'b0, 4'h0, 0, '0, 1'b0);
                nop("R7 gap");
                for (int a = 20; a < 24; a++) rd("R7 burst readback", a);
                nop("R7 gap");
            end
        end
        burst_order = 1'b0;

        // R6: deselect stops a read at once, advances after it do nothing
        rd("R6 read", 5);
        step("R6 deselect", 1'b0, 3, 1'b0, 1'b1, 4'hF, 0, '0, 1'b0);
        step("R6 advance after deselect", 1'b0, 0, 1'b1, 1'b0, 4'h0, 0, pat(6, 50), 1'b0);
        step("R6 advance after deselect", 1'b0, 0, 1'b1, 1'b0, 4'h0, 0, pat(7, 50), 1'b0);
        for (int a = 4; a < 8; a++) rd("R6 unchanged", a);
        nop("R6 end");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule